// File: doc/BRIEF.md
# Shared 64-bit System Timer with Compare Event

This block is a free-running 64-bit up-counter that all cores in a cluster share as a common time base. Software sees it through a simple 32-bit register port, where the count appears as a low word and a high word. A programmable prescaler slows the count rate. A comparator watches the count and sets a sticky event flag when the count reaches a programmed 64-bit value. The event flag can drive an interrupt line.

The comparator can optionally advance its own compare value by a programmable step each time it fires. This gives periodic events without any software reload. Software stops the counter before it writes a new count. It clears the event by writing a one to the status bit.

Top module: `gtmr_top`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: While the run bit (control bit 0) is set, the count advances by one every P+1 clocks. P is the prescaler value in control bits [15:8]. The first increment lands P+1 clock edges after the edge that sets the run bit.
- R3: The count is 64 bits wide. Offset 0x0 reads bits [31:0], offset 0x4 reads bits [63:32], and a carry out of the low word increments the high word.
- R4: When the run bit is clear, writes to 0x0 and 0x4 load the matching half of the count. While the run bit is set, such writes are ignored.
- R5: The control register at 0x8 reads back as written, with this layout: bit 0 is run, bit 1 is compare enable, bit 2 is interrupt enable, bit 3 is auto-advance, and bits [15:8] are the prescaler. All other bits read zero.
- R6: The compare value is held at 0x10 (low word) and 0x14 (high word). With compare enable set, a count that is greater than or equal to the compare value sets the event flag at the next clock edge. With compare enable clear, the flag is never set.
- R7: The event flag reads as bit 0 of 0xC and stays set until software writes 1 to that bit. Writing 0 there has no effect. A match in the same cycle as a clear leaves the flag set.
- R8: `irq` is high exactly when the event flag is set and the interrupt-enable bit is set.
- R9: With auto-advance and compare enable both set, every match adds the step held at 0x18 to the compare value, at the same edge that sets the flag.
- R10: Clearing the run bit freezes the count and restarts the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Compare interrupt |

## Verification
The assertions assume that writes to the count halves happen only while the counter is stopped. They also assume the prescaler and step stay fixed while the comparator is auto-advancing, so the model of one increment per tick holds. The stimulus always clears the run bit before it loads a count. It changes the prescaler only while the counter is stopped. It programs the step before it enables auto-advance, so the bench can predict the compare value edge by edge with a plain arithmetic model.

// File: rtl/gtmr_pkg.sv
// Package: shared register offsets and control-bit positions for the timer.
// Assumes byte offsets fit in the register-port address width.
package gtmr_pkg;
    localparam int OFF_CNT_LO  = 'h00;
    localparam int OFF_CNT_HI  = 'h04;
    localparam int OFF_CTRL    = 'h08;
    localparam int OFF_STAT    = 'h0C;
    localparam int OFF_CMP_LO  = 'h10;
    localparam int OFF_CMP_HI  = 'h14;
    localparam int OFF_STEP    = 'h18;

    localparam int BIT_RUN     = 0;
    localparam int BIT_CMP_EN  = 1;
    localparam int BIT_IRQ_EN  = 2;
    localparam int BIT_AUTO    = 3;
    localparam int PRE_LSB     = 8;
endpackage

// File: rtl/gtmr_prescaler.sv
// Module: clock divider producing one tick every (div+1) clocks while run is high.
// Assumes div is held steady while running; phase returns to zero when stopped.
module gtmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;

    // Tick when the phase has reached the divider value (>= tolerates a shrinking div).
    assign tick = run && (phase_q >= div);

    // Advance or restart the phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/gtmr_counter.sv
// Module: 64-bit count split into two halves, loadable per half, incremented on tick.
// Assumes the top only raises a load strobe while counting is stopped.
module gtmr_counter #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic [HALF_W-1:0]   ld_data,
    output logic [2*HALF_W-1:0] count
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] count_q;

    // Load a half, or step the full count on a prescaler tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) count_q[HALF_W-1:0]     <= ld_data;
            if (ld_hi) count_q[CNT_W-1:HALF_W] <= ld_data;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/gtmr_comparator.sv
// Module: 64-bit compare register with optional self-advance by a step on each hit.
// Assumes software writes to the compare halves take priority over auto-advance.
module gtmr_comparator #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*HALF_W-1:0] count,
    input  logic                cmp_en,
    input  logic                auto_en,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic                wr_step,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] cmp_val,
    output logic [HALF_W-1:0]   step_val,
    output logic                hit
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0]  cmp_q;
    logic [HALF_W-1:0] step_q;

    // A hit is a count at or past the compare value while enabled.
    assign hit = cmp_en && (count >= cmp_q);

    // Hold the compare value: software load first, else advance on hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cmp_q[HALF_W-1:0]     <= wdata;
            if (wr_hi) cmp_q[CNT_W-1:HALF_W] <= wdata;
        end else if (hit && auto_en) begin
            cmp_q <= cmp_q + CNT_W'(step_q);
        end
    end

    // Hold the auto-advance step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (wr_step) begin
            step_q <= wdata;
        end
    end

    assign cmp_val  = cmp_q;
    assign step_val = step_q;
endmodule

// File: rtl/gtmr_top.sv
// Module: shared 64-bit timer top: register decode, control, event flag, interrupt.
// Assumes a single-cycle write strobe and a combinational read of reg_addr.
module gtmr_top #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    import gtmr_pkg::*;

    localparam int CNT_W = 2 * DATA_W;

    logic              run_q, cmp_en_q, irq_en_q, auto_q, flag_q;
    logic [PRE_W-1:0]  pre_q;
    logic              tick, hit;
    logic [CNT_W-1:0]  count_q, cmp_val;
    logic [DATA_W-1:0] step_val;
    logic              sel_cnt_lo, sel_cnt_hi, sel_ctrl, sel_stat;
    logic              sel_cmp_lo, sel_cmp_hi, sel_step, clr_req;

    // Decode write strobes per register.
    always_comb begin
        sel_cnt_lo = reg_wr && (reg_addr == ADDR_W'(OFF_CNT_LO));
        sel_cnt_hi = reg_wr && (reg_addr == ADDR_W'(OFF_CNT_HI));
        sel_ctrl   = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
        sel_stat   = reg_wr && (reg_addr == ADDR_W'(OFF_STAT));
        sel_cmp_lo = reg_wr && (reg_addr == ADDR_W'(OFF_CMP_LO));
        sel_cmp_hi = reg_wr && (reg_addr == ADDR_W'(OFF_CMP_HI));
        sel_step   = reg_wr && (reg_addr == ADDR_W'(OFF_STEP));
        clr_req    = sel_stat && reg_wdata[0];
    end

    // Hold the control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            cmp_en_q <= 1'b0;
            irq_en_q <= 1'b0;
            auto_q   <= 1'b0;
            pre_q    <= '0;
        end else if (sel_ctrl) begin
            run_q    <= reg_wdata[BIT_RUN];
            cmp_en_q <= reg_wdata[BIT_CMP_EN];
            irq_en_q <= reg_wdata[BIT_IRQ_EN];
            auto_q   <= reg_wdata[BIT_AUTO];
            pre_q    <= reg_wdata[PRE_LSB +: PRE_W];
        end
    end

    gtmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run_q),
        .div  (pre_q),
        .tick (tick)
    );

    gtmr_counter #(.HALF_W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .ld_lo  (sel_cnt_lo && !run_q),
        .ld_hi  (sel_cnt_hi && !run_q),
        .ld_data(reg_wdata),
        .count  (count_q)
    );

    gtmr_comparator #(.HALF_W(DATA_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (count_q),
        .cmp_en  (cmp_en_q),
        .auto_en (auto_q),
        .wr_lo   (sel_cmp_lo),
        .wr_hi   (sel_cmp_hi),
        .wr_step (sel_step),
        .wdata   (reg_wdata),
        .cmp_val (cmp_val),
        .step_val(step_val),
        .hit     (hit)
    );

    // Sticky event flag: a hit wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    assign irq = flag_q && irq_en_q;

    // Read multiplexer for the register port.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFF_CNT_LO): reg_rdata = count_q[DATA_W-1:0];
            ADDR_W'(OFF_CNT_HI): reg_rdata = count_q[CNT_W-1:DATA_W];
            ADDR_W'(OFF_CTRL): begin
                reg_rdata[BIT_RUN]             = run_q;
                reg_rdata[BIT_CMP_EN]          = cmp_en_q;
                reg_rdata[BIT_IRQ_EN]          = irq_en_q;
                reg_rdata[BIT_AUTO]            = auto_q;
                reg_rdata[PRE_LSB +: PRE_W]    = pre_q;
            end
            ADDR_W'(OFF_STAT):   reg_rdata[0] = flag_q;
            ADDR_W'(OFF_CMP_LO): reg_rdata = cmp_val[DATA_W-1:0];
            ADDR_W'(OFF_CMP_HI): reg_rdata = cmp_val[CNT_W-1:DATA_W];
            ADDR_W'(OFF_STEP):   reg_rdata = step_val;
            default:             reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gtmr_checker.sv
// Module: temporal checks on the timer, attached to gtmr_top by bind.
// Assumes count loads only while stopped and a steady prescaler while running.
module gtmr_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int PRE_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic                irq,
    input logic                run,
    input logic                cmp_en,
    input logic                auto_en,
    input logic [PRE_W-1:0]    pre,
    input logic                flag,
    input logic                hit,
    input logic [2*DATA_W-1:0] count,
    input logic [2*DATA_W-1:0] cmp_val,
    input logic [DATA_W-1:0]   step_val
);
    import gtmr_pkg::*;

    logic wr_count, wr_cmp, wr_clear;
    assign wr_count = reg_wr && (reg_addr == ADDR_W'(OFF_CNT_LO) || reg_addr == ADDR_W'(OFF_CNT_HI));
    assign wr_cmp   = reg_wr && (reg_addr == ADDR_W'(OFF_CMP_LO) || reg_addr == ADDR_W'(OFF_CMP_HI));
    assign wr_clear = reg_wr && (reg_addr == ADDR_W'(OFF_STAT)) && reg_wdata[0];

    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_count) |=> $stable(count)); // R10

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_count) |=> (count == $past(count) || count == $past(count) + 1'b1)); // R2

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pre == '0 && !wr_count) |=> count == $past(count) + 1'b1); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_clear) |=> flag); // R7

    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R8

    AST_CMP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && auto_en && cmp_en && !wr_cmp) |=> cmp_val == $past(cmp_val) + $past(step_val)); // R9
endmodule

bind gtmr_top gtmr_checker #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .PRE_W (PRE_W)
) u_gtmr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .irq      (irq),
    .run      (run_q),
    .cmp_en   (cmp_en_q),
    .auto_en  (auto_q),
    .pre      (pre_q),
    .flag     (flag_q),
    .hit      (hit),
    .count    (count_q),
    .cmp_val  (cmp_val),
    .step_val (step_val)
);

// File: tb/gtmr_top_bench.sv
// Bench: sweeps prescaler settings, carry, loads, single and periodic compare.
module gtmr_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          checks = 0;
    int          failures = 0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gtmr_top u_gtmr_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq      (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: all registers zero after reset
        for (int a = 0; a <= 'h18; a += 4) begin
            rd(5'(a), v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset irq", {31'b0, irq}, 32'h0);

        // R2/R5: prescaler sweep, count = floor(k/(p+1))
        for (int p = 0; p < 4; p++) begin
            wr(5'h08, 32'h0);
            wr(5'h00, 32'h0);
            wr(5'h04, 32'h0);
            wr(5'h08, (32'(p) << 8) | 32'h1);
            rd(5'h08, v);
            chk("R5 control readback", v, (32'(p) << 8) | 32'h1);
            for (int k = 0; k < 12; k++) begin
                if (k > 0) @(negedge clk);
                rd(5'h00, v);
                chk("R2 prescaled count", v, 32'(k / (p + 1)));
            end
        end

        // R10: stopping freezes the count
        wr(5'h08, 32'h0);
        rd(5'h00, v);
        repeat (5) @(negedge clk);
        rd(5'h00, v2);
        chk("R10 frozen count", v2, v);

        // R3/R4: carry from low to high word, loads while stopped
        wr(5'h00, 32'hFFFF_FFFE);
        wr(5'h04, 32'h0000_0005);
        rd(5'h00, v); chk("R4 load low", v, 32'hFFFF_FFFE);
        rd(5'h04, v); chk("R4 load high", v, 32'h5);
        wr(5'h08, 32'h1);
        @(negedge clk);
        rd(5'h00, v); chk("R3 low before carry", v, 32'hFFFF_FFFF);
        rd(5'h04, v); chk("R3 high before carry", v, 32'h5);
        @(negedge clk);
        rd(5'h00, v); chk("R3 low after carry", v, 32'h0);
        rd(5'h04, v); chk("R3 high after carry", v, 32'h6);
        // R4: load ignored while running (two edges pass in the write)
        wr(5'h00, 32'h0000_1234);
        rd(5'h00, v); chk("R4 ignored load", v, 32'h2);
        // R6: comparator disabled, huge count past zero compare, no flag
        rd(5'h0C, v); chk("R6 no event when disabled", v, 32'h0);

        // R6/R8: single compare event at count 10
        wr(5'h08, 32'h0);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0);
        wr(5'h10, 32'd10);
        wr(5'h08, 32'h7);
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            if (k == 10) begin
                rd(5'h0C, v); chk("R6 no flag before match", v, 32'h0);
                chk("R8 irq low before match", {31'b0, irq}, 32'h0);
            end
        end
        rd(5'h0C, v); chk("R6 flag on match", v, 32'h1);
        chk("R8 irq with enable", {31'b0, irq}, 32'h1);
        wr(5'h08, 32'h3);
        chk("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(5'h0C, 32'h0);
        rd(5'h0C, v); chk("R7 write zero keeps flag", v, 32'h1);
        wr(5'h0C, 32'h1);
        rd(5'h0C, v); chk("R7 match beats clear", v, 32'h1);
        wr(5'h08, 32'h5);
        wr(5'h0C, 32'h1);
        rd(5'h0C, v); chk("R7 clear flag", v, 32'h0);
        chk("R8 irq after clear", {31'b0, irq}, 32'h0);

        // R9: periodic events with auto-advance, model c += step on each hit
        wr(5'h08, 32'h0);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0);
        wr(5'h10, 32'd5);
        wr(5'h14, 32'h0);
        wr(5'h18, 32'd4);
        rd(5'h18, v); chk("R9 step readback", v, 32'd4);
        wr(5'h08, 32'hB);
        c = 5;
        for (int k = 0; k <= 20; k++) begin
            if (k > 0) begin
                @(negedge clk);
                if (k - 1 >= c) c += 4;
            end
            rd(5'h10, v);
            chk("R9 advancing compare", v, 32'(c));
        end
        rd(5'h14, v); chk("R9 compare high word", v, 32'h0);
        rd(5'h0C, v); chk("R9 periodic flag", v, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule